// File: doc/BRIEF.md
# Cross-Domain Station Address Bank

This block holds a bank of 48-bit station addresses that software writes over a 32-bit host port, and it makes each address available as a coherent 48-bit value in a separate line-side receive clock domain. Each address is written as two words. The upper word carries the top 16 bits and the lower word carries the bottom 32 bits. Both words land in host-side staging registers, and host reads always return these staging values.

A transfer to the line side starts only when the host writes one specific byte lane of the lower word. In little-endian mode that lane is bits [31:24]. In big-endian mode it is bits [7:0]. When the trigger lane is written, the entry's merged 48-bit value is frozen in a hold register and a request toggle flips. A two-flop synchronizer carries the toggle into the line domain. There the edge loads the whole shadow in one cycle. An acknowledge toggle returns through a second two-flop synchronizer and clears the entry's busy flag. Each entry has its own handshake and busy flag. A trigger write made while the entry is busy still updates staging, but it launches nothing.

Top module: `addr_xdom_bank`

## Requirements
- R1: After reset, staging and line-side shadow registers hold all-ones for every entry. An upper-word read returns 0x0000FFFF, a lower-word read returns 0xFFFFFFFF, and every busy flag is 0.
- R2: A host write updates only the staging bytes whose byte enable is set, and host reads return the staging value. The address format is {entry index, word select}, with word select 1 = upper word (data bits [15:0]) and 0 = lower word.
- R3: A write to the upper word, with any byte enables, launches no transfer. The busy flag stays 0 and the shadow is unchanged.
- R4: With big_endian = 0, a lower-word write launches a transfer if and only if byte enable bit 3 is set.
- R5: With big_endian = 1, a lower-word write launches a transfer if and only if byte enable bit 0 is set.
- R6: A transfer copies {upper[15:0], lower[31:0]} into the entry's shadow as one value. That value is the staging content including the bytes of the triggering write. The shadow does not change in the cycle the trigger is written.
- R7: The busy flag is 1 in the host cycle after a launching write. It returns to 0 once the acknowledge has come back, within 20 host cycles at the bench clock ratio.
- R8: A trigger-lane write to an entry while its busy flag is 1 updates staging but launches no transfer. The shadow keeps the value of the earlier launch.
- R9: Entries are independent. A write to one entry changes neither the staging, the shadow nor the busy flag of any other entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Host clock |
| hrst_n | input | 1 | Host synchronous active-low reset |
| big_endian | input | 1 | Selects the trigger byte lane: 0 = bits [31:24], 1 = bits [7:0] |
| h_wr | input | 1 | Host write strobe |
| h_addr | input | IDX_W+1 | {entry index, word select}; word select 1 = upper word |
| h_be | input | 4 | Byte enables of the write |
| h_wdata | input | 32 | Write data |
| h_rdata | output | 32 | Staging value of the addressed word |
| h_busy | output | NUM_ENT | Per-entry transfer-in-flight flag |
| lclk | input | 1 | Line-side clock |
| lrst_n | input | 1 | Line-side synchronous active-low reset |
| l_addr | output | NUM_ENT*48 | Line-side shadow addresses, entry e at bits [e*48 +: 48] |

## Verification
The table of writes mixes full-word, single-lane and multi-lane byte enables in both endian modes. It includes lower-word writes that touch every lane except the trigger lane, which separates "any write to the low word" from "write to the trigger lane". Upper-word writes placed between triggers show that the upper half reaches the shadow only on the next trigger. Partial writes spread over several entries, compared against a bench model of all shadows, show the transfer carries the merged staging bytes and leaves other entries alone. A back-to-back trigger pair tells a suppressed second launch apart from one that overwrites the shadow.

// File: rtl/addr_xdom_pkg.sv
// Package: shared widths, word select encoding and byte-lane constants
// for the cross-domain station address bank.
package addr_xdom_pkg;
    localparam int ADDR_W  = 48;
    localparam int HI_W    = 16;
    localparam int LO_W    = 32;
    localparam int LANE_LE = 3;   // trigger lane in little-endian mode
    localparam int LANE_BE = 0;   // trigger lane in big-endian mode

    typedef enum logic {
        WSEL_LO = 1'b0,
        WSEL_HI = 1'b1
    } wsel_e;

    // Merge byte-enabled bytes of new data over an old word.
    function automatic logic [31:0] merge_bytes(
        input logic [31:0] old_w,
        input logic [31:0] new_w,
        input logic [3:0]  be
    );
        logic [31:0] r;
        for (int b = 0; b < 4; b++) begin
            r[b*8 +: 8] = be[b] ? new_w[b*8 +: 8] : old_w[b*8 +: 8];
        end
        return r;
    endfunction
endpackage

// File: rtl/sync_2ff.sv
// Module: sync_2ff
// Two-flop synchronizer for slowly changing (toggle) signals.
// Assumes the input changes at most once per several destination cycles.
module sync_2ff #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    // Two register stages in the destination domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/host_regfile.sv
// Module: host_regfile
// Host-side staging registers for all entries. Decodes writes with byte
// enables, forms the next staging value, detects trigger-lane writes
// and serves reads. Assumes h_addr = {entry index, word select}.
module host_regfile
    import addr_xdom_pkg::*;
#(
    parameter int NUM_ENT = 4,
    localparam int IDX_W  = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             big_endian,
    input  logic                             wr,
    input  logic [IDX_W:0]                   addr,
    input  logic [3:0]                       be,
    input  logic [31:0]                      wdata,
    input  logic [NUM_ENT-1:0]               busy,
    output logic [31:0]                      rdata,
    output logic [NUM_ENT-1:0]               launch,
    output logic [NUM_ENT-1:0][ADDR_W-1:0]   stage_nxt
);
    logic [NUM_ENT-1:0][HI_W-1:0] hi_q;
    logic [NUM_ENT-1:0][LO_W-1:0] lo_q;
    logic [IDX_W-1:0]             idx;
    wsel_e                        wsel;
    logic                         lane_hit;

    assign idx      = addr[IDX_W:1];
    assign wsel     = wsel_e'(addr[0]);
    assign lane_hit = big_endian ? be[LANE_BE] : be[LANE_LE];

    for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent
        logic sel;
        logic [31:0] hi_m;
        assign sel  = wr && (idx == IDX_W'(e));
        assign hi_m = merge_bytes({16'h0, hi_q[e]}, wdata, {2'b00, be[1:0]});

        // Next staging value: merge the write into the addressed word.
        always_comb begin
            stage_nxt[e] = {hi_q[e], lo_q[e]};
            if (sel && wsel == WSEL_HI) begin
                stage_nxt[e][ADDR_W-1:LO_W] = hi_m[HI_W-1:0];
            end else if (sel && wsel == WSEL_LO) begin
                stage_nxt[e][LO_W-1:0] = merge_bytes(lo_q[e], wdata, be);
            end
        end

        // Launch request: trigger lane of the low word while idle.
        assign launch[e] = sel && (wsel == WSEL_LO) && lane_hit && !busy[e];

        // Staging registers, all-ones after reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hi_q[e] <= '1;
                lo_q[e] <= '1;
            end else begin
                {hi_q[e], lo_q[e]} <= stage_nxt[e];
            end
        end
    end

    // Read mux returns staging, never the line-side shadow.
    always_comb begin
        if (wsel == WSEL_HI) rdata = {16'h0, hi_q[idx]};
        else                 rdata = lo_q[idx];
    end

    assert_hi_no_launch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr[0]) |-> (launch == '0));
    assert_launch_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(launch));
endmodule

// File: rtl/entry_xfer.sv
// Module: entry_xfer
// Per-entry cross-domain copy. A launch freezes the merged value in a
// hold register and flips a request toggle; the line domain loads the
// shadow on the synchronized edge and returns an acknowledge toggle.
// Assumes both resets are applied together so the toggles start equal.
module entry_xfer
    import addr_xdom_pkg::*;
(
    input  logic              hclk,
    input  logic              hrst_n,
    input  logic              launch,
    input  logic [ADDR_W-1:0] stage_nxt,
    output logic              busy,
    input  logic              lclk,
    input  logic              lrst_n,
    output logic [ADDR_W-1:0] shadow
);
    logic              req_tgl;
    logic [ADDR_W-1:0] hold_q;
    logic              req_l;
    logic              req_seen;
    logic              ack_h;
    logic              edge_l;

    // Host side: flip request and freeze the value on launch.
    always_ff @(posedge hclk) begin
        if (!hrst_n) begin
            req_tgl <= 1'b0;
            hold_q  <= '1;
        end else if (launch) begin
            req_tgl <= ~req_tgl;
            hold_q  <= stage_nxt;
        end
    end

    sync_2ff #(.W(1)) u_req_sync (
        .clk(lclk), .rst_n(lrst_n), .d(req_tgl), .q(req_l)
    );

    assign edge_l = req_l ^ req_seen;

    // Line side: detect the toggle edge and load the shadow at once.
    always_ff @(posedge lclk) begin
        if (!lrst_n) begin
            req_seen <= 1'b0;
            shadow   <= '1;
        end else begin
            req_seen <= req_l;
            if (edge_l) shadow <= hold_q;
        end
    end

    sync_2ff #(.W(1)) u_ack_sync (
        .clk(hclk), .rst_n(hrst_n), .d(req_seen), .q(ack_h)
    );

    assign busy = req_tgl ^ ack_h;

    assert_busy_after_launch_R7: assert property (@(posedge hclk) disable iff (!hrst_n)
        launch |=> busy);
    assert_hold_frozen_busy_R8: assert property (@(posedge hclk) disable iff (!hrst_n)
        busy |=> $stable(hold_q));
    assert_shadow_copy_R6: assert property (@(posedge lclk) disable iff (!lrst_n)
        edge_l |=> (shadow == $past(hold_q)));
endmodule

// File: rtl/addr_xdom_bank.sv
// Module: addr_xdom_bank (top)
// Bank of NUM_ENT station addresses staged on the host clock and
// mirrored coherently into the line clock domain, one handshake each.
module addr_xdom_bank
    import addr_xdom_pkg::*;
#(
    parameter int NUM_ENT = 4,
    localparam int IDX_W  = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
    input  logic                      hclk,
    input  logic                      hrst_n,
    input  logic                      big_endian,
    input  logic                      h_wr,
    input  logic [IDX_W:0]            h_addr,
    input  logic [3:0]                h_be,
    input  logic [31:0]               h_wdata,
    output logic [31:0]               h_rdata,
    output logic [NUM_ENT-1:0]        h_busy,
    input  logic                      lclk,
    input  logic                      lrst_n,
    output logic [NUM_ENT*ADDR_W-1:0] l_addr
);
    logic [NUM_ENT-1:0]             launch;
    logic [NUM_ENT-1:0][ADDR_W-1:0] stage_nxt;

    host_regfile #(.NUM_ENT(NUM_ENT)) u_regs (
        .clk(hclk), .rst_n(hrst_n), .big_endian(big_endian),
        .wr(h_wr), .addr(h_addr), .be(h_be), .wdata(h_wdata),
        .busy(h_busy), .rdata(h_rdata), .launch(launch),
        .stage_nxt(stage_nxt)
    );

    for (genvar e = 0; e < NUM_ENT; e++) begin : g_xfer
        entry_xfer u_xfer (
            .hclk(hclk), .hrst_n(hrst_n), .launch(launch[e]),
            .stage_nxt(stage_nxt[e]), .busy(h_busy[e]),
            .lclk(lclk), .lrst_n(lrst_n),
            .shadow(l_addr[e*ADDR_W +: ADDR_W])
        );
    end
endmodule

// File: tb/test_addr_xdom_bank.sv
module test_addr_xdom_bank;
    localparam int HPER = 10;
    localparam int LPER = 14;
    localparam int NE   = 4;

    logic        hclk = 0, lclk = 0, hrst_n = 0, lrst_n = 0;
    logic        big_endian = 0, h_wr = 0;
    logic [2:0]  h_addr = 0;
    logic [3:0]  h_be = 0;
    logic [31:0] h_wdata = 0;
    logic [31:0] h_rdata;
    logic [NE-1:0] h_busy;
    logic [NE*48-1:0] l_addr;

    always #(HPER/2) hclk = ~hclk;
    always #(LPER/2) lclk = ~lclk;

    addr_xdom_bank #(.NUM_ENT(NE)) i_addr_xdom_bank (
        .hclk(hclk), .hrst_n(hrst_n), .big_endian(big_endian), .h_wr(h_wr),
        .h_addr(h_addr), .h_be(h_be), .h_wdata(h_wdata), .h_rdata(h_rdata),
        .h_busy(h_busy), .lclk(lclk), .lrst_n(lrst_n), .l_addr(l_addr)
    );

    int checks = 0, fails = 0;
    logic [15:0] m_hi [NE];
    logic [31:0] m_lo [NE];
    logic [47:0] m_sh [NE];

    typedef struct packed {
        logic       mode;
        logic [1:0] ent;
        logic       hi;
        logic [3:0] be;
        logic [31:0] data;
        logic       trig;
    } vec_t;

    localparam vec_t VEC [10] = '{
        '{1'b0, 2'd0, 1'b0, 4'b1111, 32'h44332211, 1'b1},  // R4 R6
        '{1'b0, 2'd0, 1'b1, 4'b0011, 32'h0000AABB, 1'b0},  // R3
        '{1'b0, 2'd0, 1'b0, 4'b0001, 32'h000000CC, 1'b0},  // R4 wrong lane
        '{1'b0, 2'd0, 1'b0, 4'b1000, 32'h55000000, 1'b1},  // R4 R6
        '{1'b1, 2'd1, 1'b0, 4'b1000, 32'h77000000, 1'b0},  // R5 wrong lane
        '{1'b1, 2'd1, 1'b1, 4'b0001, 32'h00000012, 1'b0},  // R3
        '{1'b1, 2'd1, 1'b0, 4'b0001, 32'h00000034, 1'b1},  // R5 R6
        '{1'b0, 2'd3, 1'b1, 4'b0010, 32'h0000AB00, 1'b0},  // R2
        '{1'b0, 2'd3, 1'b0, 4'b0110, 32'h00BEEF00, 1'b0},  // R2 R4
        '{1'b0, 2'd3, 1'b0, 4'b1100, 32'h12340000, 1'b1}   // R4 R6
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mrg(input logic [31:0] o, input logic [31:0] n,
                                        input logic [3:0] be);
        logic [31:0] r;
        for (int b = 0; b < 4; b++) r[b*8 +: 8] = be[b] ? n[b*8 +: 8] : o[b*8 +: 8];
        return r;
    endfunction

    task automatic wr_word(input logic [1:0] ent, input logic hi, input logic [3:0] be,
                           input logic [31:0] d);
        h_addr = {ent, hi}; h_be = be; h_wdata = d; h_wr = 1;
        @(negedge hclk);
        h_wr = 0;
    endtask

    task automatic rd_word(input logic [1:0] ent, input logic hi, output logic [31:0] d);
        h_addr = {ent, hi};
        #1 d = h_rdata;
    endtask

    task automatic chk_all_shadows(input string req);
        for (int e = 0; e < NE; e++) chk(req, {16'h0, l_addr[e*48 +: 48]}, {16'h0, m_sh[e]});
    endtask

    initial begin
        logic [31:0] rd;
        for (int e = 0; e < NE; e++) begin m_hi[e] = '1; m_lo[e] = '1; m_sh[e] = '1; end
        repeat (4) @(negedge hclk);
        hrst_n = 1; lrst_n = 1;
        @(negedge hclk);

        // R1 reset state
        rd_word(2'd2, 1'b1, rd); chk("R1 hi read", {32'h0, rd}, 64'h0000FFFF);
        rd_word(2'd2, 1'b0, rd); chk("R1 lo read", {32'h0, rd}, 64'hFFFFFFFF);
        chk("R1 busy", {60'h0, h_busy}, 64'h0);
        chk_all_shadows("R1 shadow");

        // Vector table walk
        for (int i = 0; i < 10; i++) begin
            vec_t v;
            v = VEC[i];
            big_endian = v.mode;
            if (v.hi) m_hi[v.ent] = mrg({16'h0, m_hi[v.ent]}, v.data, {2'b00, v.be[1:0]})
                                    [15:0];
            else      m_lo[v.ent] = mrg(m_lo[v.ent], v.data, v.be);
            wr_word(v.ent, v.hi, v.be, v.data);
            chk("R7 R4 R5 R3 busy after write", {63'h0, h_busy[v.ent]}, {63'h0, v.trig});
            chk("R6 shadow not yet updated", {16'h0, l_addr[v.ent*48 +: 48]},
                {16'h0, m_sh[v.ent]});
            if (v.trig) m_sh[v.ent] = {m_hi[v.ent], m_lo[v.ent]};
            repeat (20) @(negedge hclk);
            chk("R7 busy cleared", {60'h0, h_busy}, 64'h0);
            rd_word(v.ent, v.hi, rd);
            chk("R2 staging read", {32'h0, rd},
                {32'h0, v.hi ? {16'h0, m_hi[v.ent]} : m_lo[v.ent]});
            chk_all_shadows("R6 R9 shadows");
        end

        // R8: second trigger while busy is ignored
        big_endian = 0;
        wr_word(2'd2, 1'b0, 4'b1111, 32'hA1A2A3A4);
        chk("R8 busy set", {63'h0, h_busy[2]}, 64'h1);
        wr_word(2'd2, 1'b0, 4'b1111, 32'hB1B2B3B4);
        m_sh[2] = {16'hFFFF, 32'hA1A2A3A4};
        repeat (20) @(negedge hclk);
        chk("R8 shadow keeps first", {16'h0, l_addr[2*48 +: 48]}, {16'h0, m_sh[2]});
        rd_word(2'd2, 1'b0, rd); chk("R8 staging updated", {32'h0, rd}, 64'hB1B2B3B4);
        chk("R8 busy cleared", {60'h0, h_busy}, 64'h0);
        chk_all_shadows("R9 others untouched");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(HPER * 100000);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule